// File: doc/BRIEF.md
# SD Card Host Power-Up and Initialization Sequencer

This host-side block takes a memory card from a powered-down slot to a ready state. On a start request it removes card power for a timed interval, re-applies it, waits for the supply to report stable plus a settle interval, and then runs the card clock for a preamble burst before any command goes out. The card clock stays on the slow (identification-rate) divider for the whole bring-up.

After the burst the block issues the command sequence. It sends the idle reset, then the interface-condition check with a fixed check pattern. It then runs repeated operating-condition negotiation, where every attempt is an application-command prefix followed by the negotiation command with one unchanging argument. When the card accepts low-voltage signalling, a voltage-switch request follows. A separate command/response engine serializes the commands. It returns each response as a 32-bit field plus a valid strobe, or a timeout strobe. For the reset command, which has no response, it returns the valid strobe when the command has been sent. The block ends with a held done flag, an error code, the capacity flag and the low-voltage-granted flag. On success it switches the divider select to fast.

Top module: `card_init_seq`

## Requirements
- R1: On an accepted start, `supplyOn` is low for exactly OFF_CYCLES clock cycles and then goes high. `busy` is high from the cycle after the start until the sequence ends.
- R2: After `supplyGood` is seen high, `clkEn` stays low for at least STABLE_CYCLES further cycles.
- R3: `clkEn` is never high while `supplyOn` is low. It runs for exactly BURST_CLKS*SLOW_DIV cycles before the first `cmdValid`, which is the preamble of at least BURST_CLKS slow card clocks.
- R4: `divSlow` is 1 whenever a command is issued. It becomes 0 only after a sequence ends with error code 0.
- R5: The first two commands are index 0 (argument 0) and index 8 (argument 0x000001AA). If the index 8 response times out, or its bits [11:0] differ from 0x1AA, the sequence ends with error code 1 and no further command.
- R6: Every index 41 command comes directly after an index 55 command with argument 0. Every index 41 command carries the same argument, 0x41FF8000: bit 30 requests high capacity and bit 24 requests 1.8 V signalling.
- R7: A failed attempt is a timeout on index 55, a timeout on index 41, or an index 41 response with bit 31 = 0. A failed attempt starts a new index 55/41 pair. After RETRY_LIMIT failed attempts the sequence ends with error code 2. A ready response on the last allowed attempt still succeeds.
- R8: On the index 41 response with bit 31 = 1, `highCap` takes response bit 30 and `lowVoltOk` takes response bit 24.
- R9: Index 11 (argument 0) is issued only when the latched bit 24 is 1. Otherwise the sequence ends with code 0 right after the ready response. A timeout on index 11 ends the sequence with error code 3.
- R10: `done` and `errCode` (0 ok, 1 interface check, 2 negotiation exhausted, 3 switch unanswered) hold until the next start, which clears them together with `highCap` and `lowVoltOk`.
- R11: `startReq` while `busy` is high has no effect: power is not removed and no second index 0 command is issued.
- R12: `cmdValid` is a single-cycle pulse. No new command is issued until a response or timeout has arrived for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | Begin a bring-up sequence (accepted when idle or finished) |
| supplyGood | input | 1 | Card supply reported stable |
| rspValid | input | 1 | Response field valid, or command-sent completion for index 0 |
| rspTimeout | input | 1 | No response arrived for the last command |
| rspArg | input | 32 | Parsed 32-bit response field |
| supplyOn | output | 1 | Card supply switch enable |
| clkEn | output | 1 | Card clock enable |
| divSlow | output | 1 | 1 selects the identification-rate divider |
| cmdValid | output | 1 | One-cycle command request |
| cmdIndex | output | 6 | Command index, valid with cmdValid |
| cmdArg | output | 32 | Command argument, valid with cmdValid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (held) |
| errCode | output | 2 | Result code, valid with done |
| highCap | output | 1 | Card reported high capacity |
| lowVoltOk | output | 1 | Card accepted 1.8 V signalling |

## Verification
Card response scripts exercise several negotiation paths:
- Immediate readiness against several not-ready replies tells whether the retry loop repeats the prefix/argument pair unchanged.
- Readiness on exactly the last allowed attempt against a card that never becomes ready separates an off-by-one in the retry limit from a correct bound.
- Capacity and acceptance bits set against cleared show whether the flags are latched from the ready reply and whether the switch command is gated on them.
- A bad check-pattern echo, a prefix timeout and a switch timeout each tell whether the block branches to the right end state.
- A start pulse in the middle of negotiation shows whether a restart is blocked.

// File: rtl/card_init_pkg.sv
`timescale 1ns/1ps
package card_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_OFF, S_RAMP, S_SETTLE, S_BURST,
    S_C0, S_C0W, S_C8, S_C8W, S_C55, S_C55W,
    S_A41, S_A41W, S_C11, S_C11W, S_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_IFCOND  = 2'd1,
    ERR_NEGOT   = 2'd2,
    ERR_VSWITCH = 2'd3
  } errCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     tmrClr;
    logic     attClr;
    logic     attInc;
    logic     latchOcr;
    logic     clrStatus;
    logic     setDone;
    errCode_t errVal;
  } dpCtl_t;

  localparam logic [5:0]  IDX_GO_IDLE = 6'd0;
  localparam logic [5:0]  IDX_IF_COND = 6'd8;
  localparam logic [5:0]  IDX_VSWITCH = 6'd11;
  localparam logic [5:0]  IDX_OP_COND = 6'd41;
  localparam logic [5:0]  IDX_APP     = 6'd55;
  localparam logic [31:0] IF_COND_ARG = 32'h0000_01AA;
  localparam logic [31:0] OP_COND_ARG = 32'h41FF_8000;

endpackage

// File: rtl/card_init_dp.sv
`timescale 1ns/1ps
module card_init_dp
  import card_init_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int ATT_W       = 4,
  parameter int RETRY_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             ocrCcs,
  input  logic             ocrS18,
  output logic [TMR_W-1:0] tmrVal,
  output logic             attLast,
  output logic             done,
  output errCode_t         errCode,
  output logic             highCap,
  output logic             lowVoltOk
);

  localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(RETRY_LIMIT - 1);

  logic [ATT_W-1:0] attCnt;

  // free-running saturating interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tmrVal <= '0;
    else if (ctl.tmrClr)       tmrVal <= '0;
    else if (tmrVal != '1)     tmrVal <= tmrVal + 1'b1;
  end

  // failed-attempt counter for negotiation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               attCnt <= '0;
    else if (ctl.attClr)     attCnt <= '0;
    else if (ctl.attInc)     attCnt <= attCnt + 1'b1;
  end

  assign attLast = (attCnt == ATT_LAST);

  // result and card status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done      <= 1'b0;
      errCode   <= ERR_NONE;
      highCap   <= 1'b0;
      lowVoltOk <= 1'b0;
    end else begin
      if (ctl.clrStatus) begin
        done      <= 1'b0;
        errCode   <= ERR_NONE;
        highCap   <= 1'b0;
        lowVoltOk <= 1'b0;
      end
      if (ctl.latchOcr) begin
        highCap   <= ocrCcs;
        lowVoltOk <= ocrS18;
      end
      if (ctl.setDone) begin
        done    <= 1'b1;
        errCode <= ctl.errVal;
      end
    end
  end

endmodule

// File: rtl/card_init_ctrl.sv
`timescale 1ns/1ps
module card_init_ctrl
  import card_init_pkg::*;
#(
  parameter int TMR_W         = 8,
  parameter int OFF_CYCLES    = 20,
  parameter int STABLE_CYCLES = 10,
  parameter int BURST_LEN     = 148
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             supplyGood,
  input  logic             rspValid,
  input  logic             rspTimeout,
  input  logic             rspReady,
  input  logic             rspS18,
  input  logic [11:0]      rspEcho,
  input  logic [TMR_W-1:0] tmrVal,
  input  logic             attLast,
  input  errCode_t         errCode,
  output dpCtl_t           ctl,
  output logic             supplyOn,
  output logic             clkEn,
  output logic             divSlow,
  output logic             cmdValid,
  output logic [5:0]       cmdIndex,
  output logic [31:0]      cmdArg,
  output logic             busy
);

  localparam logic [TMR_W-1:0] OFF_LAST    = TMR_W'(OFF_CYCLES - 1);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(STABLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] BURST_LAST  = TMR_W'(BURST_LEN - 1);

  seqState_t st, nxt;
  logic      attFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt     = st;
    ctl     = '0;
    attFail = 1'b0;
    case (st)
      S_IDLE, S_DONE: if (startReq) begin
        nxt = S_OFF; ctl.tmrClr = 1'b1; ctl.clrStatus = 1'b1;
      end
      S_OFF:    if (tmrVal == OFF_LAST) nxt = S_RAMP;
      S_RAMP:   if (supplyGood) begin nxt = S_SETTLE; ctl.tmrClr = 1'b1; end
      S_SETTLE: if (tmrVal == SETTLE_LAST) begin nxt = S_BURST; ctl.tmrClr = 1'b1; end
      S_BURST:  if (tmrVal == BURST_LAST) nxt = S_C0;
      S_C0:     nxt = S_C0W;
      S_C0W:    if (rspValid || rspTimeout) nxt = S_C8;
      S_C8:     nxt = S_C8W;
      S_C8W: begin
        if (rspTimeout || (rspValid && rspEcho != IF_COND_ARG[11:0])) begin
          nxt = S_DONE; ctl.setDone = 1'b1; ctl.errVal = ERR_IFCOND;
        end else if (rspValid) begin
          nxt = S_C55; ctl.attClr = 1'b1;
        end
      end
      S_C55:    nxt = S_C55W;
      S_C55W: begin
        if (rspTimeout)    attFail = 1'b1;
        else if (rspValid) nxt = S_A41;
      end
      S_A41:    nxt = S_A41W;
      S_A41W: begin
        if (rspValid && rspReady) begin
          ctl.latchOcr = 1'b1;
          if (rspS18) nxt = S_C11;
          else begin nxt = S_DONE; ctl.setDone = 1'b1; ctl.errVal = ERR_NONE; end
        end else if (rspValid || rspTimeout) begin
          attFail = 1'b1;
        end
      end
      S_C11:    nxt = S_C11W;
      S_C11W: begin
        if (rspTimeout) begin
          nxt = S_DONE; ctl.setDone = 1'b1; ctl.errVal = ERR_VSWITCH;
        end else if (rspValid) begin
          nxt = S_DONE; ctl.setDone = 1'b1; ctl.errVal = ERR_NONE;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (attFail) begin
      if (attLast) begin
        nxt = S_DONE; ctl.setDone = 1'b1; ctl.errVal = ERR_NEGOT;
      end else begin
        nxt = S_C55; ctl.attInc = 1'b1;
      end
    end
  end

  assign supplyOn = !(st inside {S_IDLE, S_OFF});
  assign clkEn    = !(st inside {S_IDLE, S_OFF, S_RAMP, S_SETTLE});
  assign busy     = !(st inside {S_IDLE, S_DONE});
  assign divSlow  = !(st == S_DONE && errCode == ERR_NONE);
  assign cmdValid = st inside {S_C0, S_C8, S_C55, S_A41, S_C11};

  always_comb begin
    cmdIndex = IDX_GO_IDLE;
    cmdArg   = '0;
    case (st)
      S_C8:  begin cmdIndex = IDX_IF_COND; cmdArg = IF_COND_ARG; end
      S_C55: cmdIndex = IDX_APP;
      S_A41: begin cmdIndex = IDX_OP_COND; cmdArg = OP_COND_ARG; end
      S_C11: cmdIndex = IDX_VSWITCH;
      default: ;
    endcase
  end

endmodule

// File: rtl/card_init_seq.sv
`timescale 1ns/1ps
module card_init_seq
  import card_init_pkg::*;
#(
  parameter int OFF_CYCLES    = 100000,
  parameter int STABLE_CYCLES = 100000,
  parameter int SLOW_DIV      = 250,
  parameter int BURST_CLKS    = 74,
  parameter int RETRY_LIMIT   = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        supplyGood,
  input  logic        rspValid,
  input  logic        rspTimeout,
  input  logic [31:0] rspArg,
  output logic        supplyOn,
  output logic        clkEn,
  output logic        divSlow,
  output logic        cmdValid,
  output logic [5:0]  cmdIndex,
  output logic [31:0] cmdArg,
  output logic        busy,
  output logic        done,
  output logic [1:0]  errCode,
  output logic        highCap,
  output logic        lowVoltOk
);

  localparam int BURST_LEN = BURST_CLKS * SLOW_DIV;
  localparam int WAIT_MAX  = (OFF_CYCLES > STABLE_CYCLES) ? OFF_CYCLES : STABLE_CYCLES;
  localparam int TMR_MAX   = (WAIT_MAX > BURST_LEN) ? WAIT_MAX : BURST_LEN;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int ATT_W     = $clog2(RETRY_LIMIT + 1);

  dpCtl_t           ctl;
  logic [TMR_W-1:0] tmrVal;
  logic             attLast;
  errCode_t         errState;
  logic             unusedRspBits;

  assign unusedRspBits = ^{rspArg[29:25], rspArg[23:12]};
  assign errCode       = errState;

  card_init_ctrl #(
    .TMR_W(TMR_W), .OFF_CYCLES(OFF_CYCLES),
    .STABLE_CYCLES(STABLE_CYCLES), .BURST_LEN(BURST_LEN)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .startReq(startReq), .supplyGood(supplyGood),
    .rspValid(rspValid), .rspTimeout(rspTimeout),
    .rspReady(rspArg[31]), .rspS18(rspArg[24]), .rspEcho(rspArg[11:0]),
    .tmrVal(tmrVal), .attLast(attLast), .errCode(errState), .ctl(ctl),
    .supplyOn(supplyOn), .clkEn(clkEn), .divSlow(divSlow),
    .cmdValid(cmdValid), .cmdIndex(cmdIndex), .cmdArg(cmdArg), .busy(busy)
  );

  card_init_dp #(
    .TMR_W(TMR_W), .ATT_W(ATT_W), .RETRY_LIMIT(RETRY_LIMIT)
  ) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ocrCcs(rspArg[30]), .ocrS18(rspArg[24]),
    .tmrVal(tmrVal), .attLast(attLast), .done(done), .errCode(errState),
    .highCap(highCap), .lowVoltOk(lowVoltOk)
  );

endmodule

// File: rtl/card_init_chk.sv
`timescale 1ns/1ps
module card_init_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startReq,
  input logic        supplyOn,
  input logic        clkEn,
  input logic        divSlow,
  input logic        cmdValid,
  input logic [5:0]  cmdIndex,
  input logic [31:0] cmdArg,
  input logic        busy,
  input logic        done,
  input logic [1:0]  errCode,
  input logic        lowVoltOk
);

  // R12
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6
  op_arg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIndex == 6'd41) |-> (cmdArg == 32'h41FF_8000));

  // R9
  vswitch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIndex == 6'd11) |-> lowVoltOk);

  // R3
  clk_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOn |-> !clkEn);

  // R4
  slow_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> divSlow);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> (done && $stable(errCode)));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && supplyOn && startReq) |=> supplyOn);

endmodule

bind card_init_seq card_init_chk chkInst (
  .clk(clk), .rstN(rstN), .startReq(startReq), .supplyOn(supplyOn),
  .clkEn(clkEn), .divSlow(divSlow), .cmdValid(cmdValid),
  .cmdIndex(cmdIndex), .cmdArg(cmdArg), .busy(busy), .done(done),
  .errCode(errCode), .lowVoltOk(lowVoltOk)
);

// File: tb/tb_card_init_seq.sv
`timescale 1ns/1ps
module tb_card_init_seq;

  localparam int OFF_C     = 20;
  localparam int STAB_C    = 10;
  localparam int DIV_C     = 2;
  localparam int BURST_C   = 74;
  localparam int RETRY_C   = 5;
  localparam int BURST_LEN = BURST_C * DIV_C;

  logic        clk = 1'b0, rstN = 1'b0, startReq = 1'b0, supplyGood = 1'b0;
  logic        rspValid = 1'b0, rspTimeout = 1'b0;
  logic [31:0] rspArg = '0;
  logic        supplyOn, clkEn, divSlow, cmdValid, busy, done, highCap, lowVoltOk;
  logic [5:0]  cmdIndex;
  logic [31:0] cmdArg;
  logic [1:0]  errCode;

  card_init_seq #(
    .OFF_CYCLES(OFF_C), .STABLE_CYCLES(STAB_C), .SLOW_DIV(DIV_C),
    .BURST_CLKS(BURST_C), .RETRY_LIMIT(RETRY_C)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .supplyGood(supplyGood),
    .rspValid(rspValid), .rspTimeout(rspTimeout), .rspArg(rspArg),
    .supplyOn(supplyOn), .clkEn(clkEn), .divSlow(divSlow), .cmdValid(cmdValid),
    .cmdIndex(cmdIndex), .cmdArg(cmdArg), .busy(busy), .done(done),
    .errCode(errCode), .highCap(highCap), .lowVoltOk(lowVoltOk)
  );

  int vectors = 0, miscompares = 0;

  // card response script
  int notReadyLeft = 0, tmo55Left = 0;
  bit echoBad = 0, ocrCcs = 0, ocrS18 = 0, tmo11 = 0;

  // observation log
  int          nCmd = 0;
  int          cmdIdxLog [64];
  logic [31:0] cmdArgLog [64];
  int          offLows = 0, burstCycles = 0, rampCnt = 0;
  time         goodAt = 0, clkEnAt = 0;
  bit          clkEnSeen = 0, cmdSeen = 0, slowViol = 0;
  int          rIdx;
  logic [31:0] rArg;

  initial forever #5 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  // monitor: samples outputs at the falling edge
  initial forever begin
    @(negedge clk);
    if (busy && !supplyOn) offLows++;
    if (busy && clkEn && !clkEnSeen) begin clkEnSeen = 1; clkEnAt = $time; end
    if (busy && clkEn && !cmdValid && !cmdSeen) burstCycles++;
    if (cmdValid) begin
      cmdSeen = 1;
      if (nCmd < 64) begin
        cmdIdxLog[nCmd] = int'(cmdIndex);
        cmdArgLog[nCmd] = cmdArg;
      end
      nCmd++;
      if (!divSlow) slowViol = 1;
    end
  end

  // supply model: reports good three cycles after power is applied
  initial forever begin
    @(negedge clk);
    if (!supplyOn) begin
      supplyGood = 0;
      rampCnt = 0;
    end else if (!supplyGood) begin
      rampCnt++;
      if (rampCnt == 3) begin supplyGood = 1; goodAt = $time; end
    end
  end

  // card / command engine model
  initial forever begin
    @(negedge clk);
    if (cmdValid) begin
      rIdx = int'(cmdIndex);
      rArg = cmdArg;
      repeat (2) @(negedge clk);
      case (rIdx)
        8: begin
          rspArg = echoBad ? 32'h0000_01A5 : rArg;
          rspValid = 1;
        end
        55: begin
          if (tmo55Left > 0) begin tmo55Left--; rspTimeout = 1; end
          else begin rspArg = 32'h0000_0120; rspValid = 1; end
        end
        41: begin
          if (notReadyLeft > 0) begin notReadyLeft--; rspArg = 32'h00FF_8000; end
          else rspArg = 32'h80FF_8000 | (32'(ocrCcs) << 30) | (32'(ocrS18) << 24);
          rspValid = 1;
        end
        11: begin
          rspArg = '0;
          if (tmo11) rspTimeout = 1; else rspValid = 1;
        end
        default: begin rspArg = '0; rspValid = 1; end
      endcase
      @(posedge clk);
      #1;
      rspValid = 0;
      rspTimeout = 0;
    end
  end

  task automatic chk(input string tag, input bit ok, input string act, input string exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %s expected %s", tag, act, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    chk(tag, act == exp, $sformatf("%0d", act), $sformatf("%0d", exp));
  endtask

  function automatic string seqStr();
    string s = "";
    for (int i = 0; i < nCmd && i < 64; i++)
      s = {s, (i == 0) ? "" : ",", $sformatf("%0d", cmdIdxLog[i])};
    return s;
  endfunction

  function automatic int countIdx(input int v);
    int n = 0;
    for (int i = 0; i < nCmd && i < 64; i++) if (cmdIdxLog[i] == v) n++;
    return n;
  endfunction

  function automatic bit argsOk();
    bit ok = 1;
    for (int i = 0; i < nCmd && i < 64; i++) begin
      case (cmdIdxLog[i])
        8:       if (cmdArgLog[i] != 32'h0000_01AA) ok = 0;
        41:      if (cmdArgLog[i] != 32'h41FF_8000) ok = 0;
        default: if (cmdArgLog[i] != 32'h0) ok = 0;
      endcase
    end
    return ok;
  endfunction

  function automatic bit pairsOk();
    bit ok = 1;
    for (int i = 0; i < nCmd && i < 64; i++)
      if (cmdIdxLog[i] == 41 && (i == 0 || cmdIdxLog[i-1] != 55)) ok = 0;
    return ok;
  endfunction

  task automatic script(input int nr, input int t55, input bit eb,
                        input bit ccs, input bit s18, input bit t11);
    notReadyLeft = nr; tmo55Left = t55; echoBad = eb;
    ocrCcs = ccs; ocrS18 = s18; tmo11 = t11;
  endtask

  // start a sequence and wait for done; optionally pulse start mid-negotiation
  task automatic runSeq(input bit midStart);
    bit pulsed = 0;
    int n = 0;
    nCmd = 0; offLows = 0; burstCycles = 0;
    clkEnSeen = 0; cmdSeen = 0; slowViol = 0;
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (midStart && !pulsed && countIdx(41) >= 1) begin startReq = 1; pulsed = 1; end
      else startReq = 0;
    end
    startReq = 0;
    chkInt("R10 sequence completes", int'(done), 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chkInt("R1 reset supplyOn", int'(supplyOn), 0);
    chkInt("R3 reset clkEn", int'(clkEn), 0);
    chkInt("R1 reset busy", int'(busy), 0);
    chkInt("R10 reset done", int'(done), 0);
    chkInt("R12 reset cmdValid", int'(cmdValid), 0);
    chkInt("R4 reset divSlow", int'(divSlow), 1);
    rstN = 1;
  endtask

  task automatic testNominal();
    int settle;
    script(2, 0, 0, 1, 1, 0);
    runSeq(0);
    settle = int'((clkEnAt - goodAt) / 10);
    chkInt("R1 power-off length", offLows, OFF_C);
    chk("R2 settle wait", settle >= STAB_C && settle <= STAB_C + 1,
        $sformatf("%0d", settle), $sformatf("%0d..%0d", STAB_C, STAB_C + 1));
    chkInt("R3 clock preamble length", burstCycles, BURST_LEN);
    chk("R5 R6 R9 command order", seqStr() == "0,8,55,41,55,41,55,41,11",
        seqStr(), "0,8,55,41,55,41,55,41,11");
    chkInt("R6 frozen arguments", int'(argsOk()), 1);
    chkInt("R6 prefix pairing", int'(pairsOk()), 1);
    chkInt("R4 slow divider during commands", int'(slowViol), 0);
    chkInt("R10 nominal errCode", int'(errCode), 0);
    chkInt("R8 highCap latched 1", int'(highCap), 1);
    chkInt("R8 lowVoltOk latched 1", int'(lowVoltOk), 1);
    chkInt("R4 fast divider after success", int'(divSlow), 0);
  endtask

  task automatic testNoSwitch();
    script(0, 0, 0, 0, 0, 0);
    runSeq(0);
    chkInt("R1 power-off length on restart", offLows, OFF_C);
    chk("R9 no switch when not accepted", seqStr() == "0,8,55,41", seqStr(), "0,8,55,41");
    chkInt("R8 highCap latched 0", int'(highCap), 0);
    chkInt("R8 lowVoltOk latched 0", int'(lowVoltOk), 0);
    chkInt("R9 errCode without switch", int'(errCode), 0);
    chkInt("R4 fast divider no switch", int'(divSlow), 0);
  endtask

  task automatic testEchoBad();
    script(0, 0, 1, 0, 0, 0);
    runSeq(0);
    chk("R5 stop after bad echo", seqStr() == "0,8", seqStr(), "0,8");
    chkInt("R5 errCode interface", int'(errCode), 1);
    chkInt("R4 divider stays slow on error", int'(divSlow), 1);
  endtask

  task automatic testExhausted();
    script(1000, 0, 0, 1, 1, 0);
    runSeq(0);
    chkInt("R7 attempts before giving up", countIdx(41), RETRY_C);
    chkInt("R7 errCode negotiation", int'(errCode), 2);
    chkInt("R8 highCap not latched on failure", int'(highCap), 0);
    chkInt("R6 prefix pairing on retries", int'(pairsOk()), 1);
  endtask

  task automatic testLastAttempt();
    script(RETRY_C - 1, 0, 0, 1, 0, 0);
    runSeq(0);
    chkInt("R7 ready on last attempt count", countIdx(41), RETRY_C);
    chkInt("R7 ready on last attempt errCode", int'(errCode), 0);
    chkInt("R8 highCap on last attempt", int'(highCap), 1);
  endtask

  task automatic testPrefixTimeout();
    script(0, 1, 0, 0, 0, 0);
    runSeq(0);
    chk("R7 prefix timeout retries", seqStr() == "0,8,55,55,41", seqStr(), "0,8,55,55,41");
    chkInt("R7 prefix timeout errCode", int'(errCode), 0);
  endtask

  task automatic testBusyStart();
    script(3, 0, 0, 0, 0, 0);
    runSeq(1);
    chkInt("R11 no second reset command", countIdx(0), 1);
    chkInt("R11 power not removed again", offLows, OFF_C);
    chkInt("R11 sequence unaffected", int'(errCode), 0);
  endtask

  task automatic testSwitchTimeout();
    script(0, 0, 0, 1, 1, 1);
    runSeq(0);
    chk("R9 switch issued", seqStr() == "0,8,55,41,11", seqStr(), "0,8,55,41,11");
    chkInt("R9 errCode switch timeout", int'(errCode), 3);
    chkInt("R8 lowVoltOk kept", int'(lowVoltOk), 1);
    chkInt("R4 slow after switch failure", int'(divSlow), 1);
  endtask

  task automatic testHoldClear();
    repeat (50) @(negedge clk);
    chkInt("R10 done held", int'(done), 1);
    chkInt("R10 errCode held", int'(errCode), 3);
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
    chkInt("R10 start clears done", int'(done), 0);
    chkInt("R10 start clears errCode", int'(errCode), 0);
    chkInt("R10 start clears lowVoltOk", int'(lowVoltOk), 0);
    chkInt("R1 busy after start", int'(busy), 1);
  endtask

  initial begin
    testReset();
    testNominal();
    testNoSwitch();
    testEchoBad();
    testExhausted();
    testLastAttempt();
    testPrefixTimeout();
    testBusyStart();
    testSwitchTimeout();
    testHoldClear();
    summary();
    $finish;
  end

endmodule